// File: doc/BRIEF.md
# Four-Mode Timer/Counter Pair

This block holds two 16-bit timer/counters, each made of an 8-bit low half and an 8-bit high half. Each timer advances either on an internal tick that fires once every twelve clocks, or on falling edges seen on its own external count pin. Its run bit starts it. A gate option makes counting also depend on the level of a separate gate pin. When a timer rolls over, it raises an overflow flag. The flag stays set until software writes the control byte.

Each timer has a 4-bit configuration nibble that picks one of four modes:
- a 13-bit count, in which five bits of the low half act as a divide-by-32 stage in front of the high half;
- a plain 16-bit count;
- an 8-bit count in the low half that reloads from the high half on every wrap;
- a split mode. Here timer 0 becomes two independent 8-bit counters, and the second counter borrows timer 1's run bit and overflow flag. The same mode, given to timer 1, freezes it.

Software reaches all registers through one write port and one combinational read port, both indexed by a 3-bit register select.

Top module: `tmr_pair`

## Requirements
- R1: Synchronous reset clears all four count halves, the configuration byte, both run bits and both overflow flags.
- R2: The internal tick fires on the 12th rising clock edge after reset is released and on every 12th edge after that. A timer with its source bit at 0 advances only on those edges.
- R3: A timer advances only while its run bit is 1 and either its gate bit is 0 or its gate pin `ext_gate[i]` is high. Clearing the run bit freezes the count without changing it.
- R4: Mode 1 (mode bits 01) counts {high, low} as one 16-bit value. The flag is set when the value wraps from FFFFh to 0000h.
- R5: Mode 0 (mode bits 00) counts the 13-bit value {high, low[4:0]}. Bits low[7:5] keep their value. The flag is set when the value wraps from 1FFFh to 0.
- R6: Mode 2 (mode bits 10) advances only the low half. When the low half is at FFh, an increment loads it from the high half and sets the flag. The high half never changes by counting.
- R7: With the source bit at 1, `ext_cnt[i]` is sampled on each internal tick edge. One increment happens when the previous sample was 1 and the current one is 0.
- R8: With timer 0 in mode 3 (mode bits 11):
  - The low half of timer 0 uses timer 0's run bit, gate and source, and sets flag 0 when it wraps from FFh.
  - The high half of timer 0 counts internal ticks whenever timer 1's run bit is 1, and sets flag 1 when it wraps from FFh.
- R9: Timer 1 in mode 3 holds both of its halves.
- R10: While timer 0 is in mode 3, timer 1 keeps counting in its own mode, but its wraps do not set flag 1.
- R11: A register write takes effect at the next rising edge and wins over an increment at that edge.
  - In modes 0 to 2, a write to either half of a timer cancels that timer's increment at that edge.
  - In mode 3, a write cancels only the increment of the half it writes.
- R12: Register select values:
  - 0 = timer 0 low, 1 = timer 0 high, 2 = timer 1 low, 3 = timer 1 high, 4 = configuration, 5 = control. Selects 6 and 7 read as 0.
  - Configuration bits [3:0] belong to timer 0 and bits [7:4] to timer 1. Each nibble is, from its top bit down: gate, source, mode[1:0].
  - Control bits are 7 = flag 1, 6 = run 1, 5 = flag 0, 4 = run 0. Bits [3:0] read as 0.
  - A control write loads both flags from the written data and wins over a flag being set at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 8 | Read data (combinational) |
| ext_cnt | input | 2 | External count pins, bit i feeds timer i |
| ext_gate | input | 2 | Gate pins, bit i gates timer i |
| ovf_flag | output | 2 | Overflow flags, bit i is flag i |

## Verification
The bench sweeps every counting mode on both timers, from one seed next to rollover and one seed far from it. For every run it computes the expected halves and flag from the number of ticks its own phase counter saw while the run bit was set. This separates the wrap points of the 13-bit, 16-bit and reload modes, and shows the preserved low bits in mode 0.

Gate-low against gate-high runs show the run condition. A slow square wave on a count pin shows that edges are counted and clock ticks are not.

Split-mode runs, with timer 1 preloaded near or far from rollover, tell apart which counter drives flag 1. Writes placed exactly on a tick edge show whether the write or the increment wins.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // width of each count half
    localparam int TW = 8;
    // number of timers in the pair
    localparam int NT = 2;

    typedef enum logic [1:0] {
        MD_13B    = 2'b00,
        MD_16B    = 2'b01,
        MD_RELOAD = 2'b10,
        MD_SPLIT  = 2'b11
    } tmode_e;

    // one configuration nibble, msb first: gate, source, mode
    typedef struct packed {
        logic   gate;
        logic   ext_src;
        tmode_e mode;
    } tcfg_t;

    typedef enum logic [2:0] {
        SEL_LO0  = 3'd0,
        SEL_HI0  = 3'd1,
        SEL_LO1  = 3'd2,
        SEL_HI1  = 3'd3,
        SEL_CFG  = 3'd4,
        SEL_CTRL = 3'd5
    } rsel_e;

    function automatic tcfg_t cfg_of(input logic [7:0] b, input int idx);
        return tcfg_t'(b[idx*4 +: 4]);
    endfunction

    // packs run bits and flags into the control byte layout
    function automatic logic [7:0] ctrl_pack(input logic [1:0] flg, input logic [1:0] run);
        return {flg[1], run[1], flg[0], run[0], 4'b0000};
    endfunction

endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
    parameter int PRESC = 12,
    parameter int NCH   = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pin,
    output logic           tick,
    output logic [NCH-1:0] fall
);
    localparam int CW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [CW-1:0] C_ONE  = 1;
    localparam logic [CW-1:0] C_LAST = CW'(PRESC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == C_LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + C_ONE;
    end

    assign tick = (cnt_q == C_LAST);

    // one sample per machine tick; a 1 -> 0 change between samples is an event
    for (genvar i = 0; i < NCH; i++) begin : g_smp
        logic smp_q;
        always_ff @(posedge clk) begin
            if (rst)       smp_q <= 1'b0;
            else if (tick) smp_q <= pin[i];
        end
        assign fall[i] = tick & smp_q & ~pin[i];
    end

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int DW        = 8,
    parameter int PRE_BITS  = 5,
    parameter bit CAN_SPLIT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  tmode_e        mode,
    input  logic          inc_a,
    input  logic          inc_b,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] lo,
    output logic [DW-1:0] hi,
    output logic          ovf_a,
    output logic          ovf_b
);
    localparam logic [DW-1:0]       ONE   = 1;
    localparam logic [2*DW-1:0]     W_ONE = 1;
    localparam logic [PRE_BITS-1:0] P_ONE = 1;

    logic          split, halt, blk_a, go_a, go_b;
    logic [DW-1:0] lo_n, hi_n;

    assign split = CAN_SPLIT && (mode == MD_SPLIT);
    assign halt  = !CAN_SPLIT && (mode == MD_SPLIT);
    assign blk_a = split ? wr_lo : (wr_lo | wr_hi);
    assign go_a  = inc_a & ~blk_a & ~halt;
    assign go_b  = split & inc_b & ~wr_hi;

    always_comb begin
        lo_n  = lo;
        hi_n  = hi;
        ovf_a = 1'b0;
        ovf_b = 1'b0;
        if (go_a) begin
            case (mode)
                MD_13B: begin
                    if (&lo[PRE_BITS-1:0]) begin
                        lo_n[PRE_BITS-1:0] = '0;
                        hi_n  = hi + ONE;
                        ovf_a = &hi;
                    end else begin
                        lo_n[PRE_BITS-1:0] = lo[PRE_BITS-1:0] + P_ONE;
                    end
                end
                MD_16B: begin
                    {hi_n, lo_n} = {hi, lo} + W_ONE;
                    ovf_a = &{hi, lo};
                end
                MD_RELOAD: begin
                    if (&lo) begin
                        lo_n  = hi;
                        ovf_a = 1'b1;
                    end else begin
                        lo_n = lo + ONE;
                    end
                end
                default: begin
                    lo_n  = lo + ONE;
                    ovf_a = &lo;
                end
            endcase
        end
        if (go_b) begin
            hi_n  = hi + ONE;
            ovf_b = &hi;
        end
        if (wr_lo) lo_n = wdata;
        if (wr_hi) hi_n = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= lo_n;
            hi <= hi_n;
        end
    end

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int PRESC    = 12,
    parameter int PRE_BITS = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [TW-1:0] wr_data,
    input  logic [2:0]    rd_sel,
    output logic [TW-1:0] rd_data,
    input  logic [NT-1:0] ext_cnt,
    input  logic [NT-1:0] ext_gate,
    output logic [NT-1:0] ovf_flag
);
    logic [7:0]    mode_q;
    logic [NT-1:0] tr_q, tf_q;
    logic          tick;
    logic [NT-1:0] fall;
    logic [NT-1:0] inc_a, inc_b, wr_lo, wr_hi, ovf_a, ovf_b, tf_set;
    logic [TW-1:0] lo_v [NT];
    logic [TW-1:0] hi_v [NT];
    logic          t0_split;
    logic          wr_cfg, wr_ctl;

    tmr_tick #(.PRESC(PRESC), .NCH(NT)) tick_i (
        .clk  (clk),
        .rst  (rst),
        .pin  (ext_cnt),
        .tick (tick),
        .fall (fall)
    );

    assign wr_cfg   = wr_en && (wr_sel == SEL_CFG);
    assign wr_ctl   = wr_en && (wr_sel == SEL_CTRL);
    assign t0_split = (cfg_of(mode_q, 0).mode == MD_SPLIT);

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        tcfg_t cfg;
        logic  run, src;
        assign cfg      = cfg_of(mode_q, i);
        assign run      = tr_q[i] & (~cfg.gate | ext_gate[i]);
        assign src      = cfg.ext_src ? fall[i] : tick;
        assign inc_a[i] = run & src;
        assign wr_lo[i] = wr_en && (wr_sel == 3'(2 * i));
        assign wr_hi[i] = wr_en && (wr_sel == 3'(2 * i + 1));

        // only the first timer can split; its upper half runs on the neighbour's run bit
        if (i == 0) begin : g_split
            assign inc_b[i] = tick & tr_q[NT-1];
        end else begin : g_plain
            assign inc_b[i] = 1'b0;
        end

        tmr_unit #(
            .DW       (TW),
            .PRE_BITS (PRE_BITS),
            .CAN_SPLIT(i == 0)
        ) unit_i (
            .clk   (clk),
            .rst   (rst),
            .mode  (cfg.mode),
            .inc_a (inc_a[i]),
            .inc_b (inc_b[i]),
            .wr_lo (wr_lo[i]),
            .wr_hi (wr_hi[i]),
            .wdata (wr_data),
            .lo    (lo_v[i]),
            .hi    (hi_v[i]),
            .ovf_a (ovf_a[i]),
            .ovf_b (ovf_b[i])
        );
    end

    // flag 1 is taken over by the split upper half of timer 0
    assign tf_set[0] = ovf_a[0];
    assign tf_set[1] = t0_split ? ovf_b[0] : ovf_a[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            tr_q   <= '0;
            tf_q   <= '0;
        end else begin
            if (wr_cfg) mode_q <= wr_data;
            if (wr_ctl) begin
                tr_q <= {wr_data[6], wr_data[4]};
                tf_q <= {wr_data[7], wr_data[5]};
            end else begin
                tf_q <= tf_q | tf_set;
            end
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_LO0:  rd_data = lo_v[0];
            SEL_HI0:  rd_data = hi_v[0];
            SEL_LO1:  rd_data = lo_v[1];
            SEL_HI1:  rd_data = hi_v[1];
            SEL_CFG:  rd_data = mode_q;
            SEL_CTRL: rd_data = ctrl_pack(tf_q, tr_q);
            default:  rd_data = '0;
        endcase
    end

    assign ovf_flag = tf_q;

endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] cfg,
    input logic [1:0] tr,
    input logic [1:0] tf,
    input logic [7:0] lo0,
    input logic [7:0] hi0,
    input logic [7:0] lo1,
    input logic [7:0] hi1,
    input logic       wr_en,
    input logic [2:0] wr_sel
);
    logic wr_t0, wr_t1, wr_ct;
    assign wr_t0 = wr_en && (wr_sel == 3'd0 || wr_sel == 3'd1);
    assign wr_t1 = wr_en && (wr_sel == 3'd2 || wr_sel == 3'd3);
    assign wr_ct = wr_en && (wr_sel == 3'd5);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tf == 2'b00 && tr == 2'b00 && cfg == 8'h00 &&
                        {hi0, lo0, hi1, lo1} == 32'h0));

    assert_halt_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!tr[0] && cfg[1:0] != 2'b11 && !wr_t0) |=> $stable({hi0, lo0}));

    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(tf[0]) && $past(cfg[1:0]) == 2'b01 && !$past(wr_ct)) |-> ({hi0, lo0} == 16'h0));

    assert_reload_src_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg[1:0] == 2'b10 && !(wr_en && wr_sel == 3'd1)) |=> $stable(hi0));

    assert_t1_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg[5:4] == 2'b11 && !wr_t1) |=> $stable({hi1, lo1}));

endmodule

bind tmr_pair tmr_pair_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .cfg    (mode_q),
    .tr     (tr_q),
    .tf     (tf_q),
    .lo0    (lo_v[0]),
    .hi0    (hi_v[0]),
    .lo1    (lo_v[1]),
    .hi1    (hi_v[1]),
    .wr_en  (wr_en),
    .wr_sel (wr_sel)
);

// File: tb/tmr_pair_tb_top.sv
`timescale 1ns/1ps
module tmr_pair_tb_top;
    localparam int PRESC = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_sel = 3'd0;
    logic [7:0] rd_data;
    logic [1:0] ext_cnt = 2'b11;
    logic [1:0] ext_gate = 2'b00;
    logic [1:0] ovf_flag;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int phase = 0;
    int tk [2];
    bit [1:0] run_m = 2'b00;

    tmr_pair #(.PRESC(PRESC), .PRE_BITS(5)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .ext_cnt(ext_cnt), .ext_gate(ext_gate),
        .ovf_flag(ovf_flag)
    );

    always #5 clk = ~clk;

    // bench view of the machine tick: 12th edge after reset, then every 12th
    always @(posedge clk) begin
        if (rst) phase = 0;
        else if (phase == PRESC - 1) begin
            if (run_m[0]) tk[0]++;
            if (run_m[1]) tk[1]++;
            phase = 0;
        end else phase++;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int sel, output int v);
        rd_sel = 3'(sel);
        #1;
        v = int'(rd_data);
    endtask

    // run-bit change placed off a tick edge so flags read back stay exact
    task automatic ctrl(input bit r1, input bit r0);
        @(negedge clk);
        while (phase == PRESC - 1) @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd5;
        wr_data = {ovf_flag[1], r1, ovf_flag[0], r0, 4'b0000};
        @(negedge clk);
        wr_en = 1'b0;
        run_m = {r1, r0};
    endtask

    task automatic model(input int m, input int n, input int lo_i, input int hi_i,
                         output int lo_o, output int hi_o, output bit ov);
        int v;
        ov = 0;
        case (m)
            0: begin
                v = (hi_i << 5) + (lo_i & 31) + n;
                if (v >= 8192) ov = 1;
                v = v % 8192;
                lo_o = (lo_i & 8'hE0) | (v & 31);
                hi_o = v >> 5;
            end
            1: begin
                v = (hi_i << 8) + lo_i + n;
                if (v >= 65536) ov = 1;
                v = v % 65536;
                lo_o = v & 255;
                hi_o = v >> 8;
            end
            default: begin
                lo_o = lo_i;
                hi_o = hi_i;
                for (int k = 0; k < n; k++) begin
                    if (lo_o == 255) begin lo_o = hi_o; ov = 1; end
                    else lo_o++;
                end
            end
        endcase
    endtask

    function automatic int seed(input int m, input int s);
        case (m)
            0: return (s == 0) ? 16'hFFFB : 16'h12A5;
            1: return (s == 0) ? 16'hFFFA : 16'h1234;
            default: return (s == 0) ? 16'hF0FC : 16'h0010;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v, lo_e, hi_e, lo_a, hi_a, sd;
        bit ov;
        string rq;
        tk[0] = 0; tk[1] = 0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: everything cleared by reset
        for (int s = 0; s < 6; s++) begin
            rd(s, v);
            chk("R1 reg", v, 0);
        end
        chk("R1 flags", int'(ovf_flag), 0);

        // R12: register layout and control write semantics
        wr(4, 8'h5A); rd(4, v); chk("R12 cfg", v, 8'h5A);
        wr(5, 8'hAF); rd(5, v); chk("R12 ctrl", v, 8'hA0);
        chk("R12 flags", int'(ovf_flag), 3);
        rd(6, v); chk("R12 unused sel", v, 0);
        wr(5, 8'h00); chk("R12 flag clear", int'(ovf_flag), 0);

        // R2/R4/R5/R6: sweep modes 0..2 on both timers, two seeds each
        for (int t = 0; t < 2; t++) begin
            for (int m = 0; m < 3; m++) begin
                for (int s = 0; s < 2; s++) begin
                    rq = (m == 0) ? "R2/R5" : (m == 1) ? "R2/R4" : "R2/R6";
                    sd = seed(m, s);
                    ctrl(0, 0);
                    wr(4, (m << (4 * t)));
                    wr(5, 0);
                    wr(2 * t, sd & 255);
                    wr(2 * t + 1, sd >> 8);
                    tk[t] = 0;
                    ctrl(t == 1, t == 0);
                    repeat (130) @(negedge clk);
                    ctrl(0, 0);
                    model(m, tk[t], sd & 255, sd >> 8, lo_e, hi_e, ov);
                    rd(2 * t, lo_a); chk({rq, " low"}, lo_a, lo_e);
                    rd(2 * t + 1, hi_a); chk({rq, " high"}, hi_a, hi_e);
                    chk({rq, " flag"}, int'(ovf_flag[t]), int'(ov));
                end
            end
        end

        // R3: gate low blocks counting, gate high lets it run, halt holds
        wr(4, 8'h09); wr(5, 0); wr(0, 0); wr(1, 0);
        ext_gate = 2'b00;
        ctrl(0, 1); repeat (100) @(negedge clk); ctrl(0, 0);
        rd(0, v); chk("R3 gate low", v, 0);
        ext_gate = 2'b01; tk[0] = 0;
        ctrl(0, 1); repeat (100) @(negedge clk); ctrl(0, 0);
        rd(0, v); chk("R3 gate high", v, tk[0]);
        repeat (60) @(negedge clk);
        rd(0, lo_a); chk("R3 halt holds", lo_a, v);
        ext_gate = 2'b00;

        // R7: timer 1 counts falling edges of its pin, not clock ticks
        wr(4, 8'h50); wr(2, 0); wr(3, 0);
        ctrl(1, 0);
        for (int p = 0; p < 5; p++) begin
            ext_cnt[1] = 1'b0; repeat (30) @(negedge clk);
            ext_cnt[1] = 1'b1; repeat (30) @(negedge clk);
        end
        ctrl(0, 0);
        rd(2, v); chk("R7 edge count", v, 5);

        // R8: split timer 0, both halves wrap and set both flags
        wr(4, 8'h13); wr(5, 0);
        wr(0, 8'hFD); wr(1, 8'hFE); wr(2, 0); wr(3, 0);
        tk[0] = 0; tk[1] = 0;
        ctrl(1, 1); repeat (130) @(negedge clk); ctrl(0, 0);
        rd(0, v); chk("R8 split low", v, (8'hFD + tk[0]) % 256);
        rd(1, v); chk("R8 split high", v, (8'hFE + tk[1]) % 256);
        chk("R8 flags", int'(ovf_flag), 3);

        // R10: timer 1 wraps while timer 0 is split: no flag 1, count continues
        wr(5, 0); wr(0, 0); wr(1, 0); wr(2, 8'hFC); wr(3, 8'hFF);
        tk[1] = 0;
        ctrl(1, 0); repeat (130) @(negedge clk); ctrl(0, 0);
        chk("R10 flag1 quiet", int'(ovf_flag[1]), 0);
        rd(2, v); chk("R10 t1 low", v, (8'hFC + tk[1]) % 256);
        rd(1, v); chk("R10 split high", v, tk[1] % 256);

        // R9: timer 1 in mode 3 is frozen
        wr(4, 8'h30); wr(2, 8'h55); wr(3, 8'h44);
        ctrl(1, 0); repeat (100) @(negedge clk); ctrl(0, 0);
        rd(2, v); chk("R9 low held", v, 8'h55);
        rd(3, v); chk("R9 high held", v, 8'h44);

        // R11: writes placed on a tick edge beat the increment
        wr(4, 8'h01); wr(0, 0); wr(1, 0);
        ctrl(0, 1); repeat (40) @(negedge clk);
        while (phase != PRESC - 1) @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h80;
        @(negedge clk); wr_en = 1'b0;
        rd(0, v); chk("R11 low write wins", v, 8'h80);
        @(negedge clk);
        while (phase != PRESC - 1) @(negedge clk);
        rd(0, lo_a);
        wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h33;
        @(negedge clk); wr_en = 1'b0;
        rd(0, v); chk("R11 high write cancels low", v, lo_a);
        rd(1, v); chk("R11 high value", v, 8'h33);
        ctrl(0, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule